// File: doc/BRIEF.md
# Predicated Integer Execute Unit

This block is the integer execute stage of a predicated 64-bit core. Each cycle it accepts one decoded operation together with two register operands, a raw immediate field with a size selector, and a shift-count field. It returns the result one clock later. Supported operations are add, add with an extra one, subtract, subtract with an extra one taken off, shifted add, four bitwise operations, left shift, and arithmetic and logical right shift. Register reads, decode, multiply and divide are handled elsewhere.

Each operation is gated by a qualifying-predicate bit. A false predicate, or an invalid slot, suppresses the write. The result register then keeps its old value, and the write-enable output stays low for that cycle. For add, subtract and the bitwise operations, the immediate is sign-extended and takes the place of the first operand. For shifts, the count comes either from the second register operand, using its full 64-bit value, or from the 6-bit count field.

Top module: `pred_int_alu`

## Requirements
- R1: While rst_ni is low, res_o and wen_o are zero.
- R2: Operation code 0 gives first + second, and code 1 gives first + second + 1. The result appears on res_o one clock after the operation is presented.
- R3: Operation code 2 gives first − second, and code 3 gives first − second − 1 (modulo 2^64).
- R4: Operation code 4 shifts src_a_i left by cnt_i[1:0]+1 positions, so field values 0..3 mean shifts of 1..4, and then adds src_b_i.
- R5: The bitwise operations are code 5 for AND, 6 for OR, 7 for XOR and 8 for first AND NOT src_b_i.
- R6: When use_imm_i is 1, the first operand of codes 0..3 and 5..8 is imm_i sign-extended to 64 bits. The source bits depend on imm_sz_i: 0 takes bits [7:0], 1 takes bits [13:0], and 2 or 3 takes bits [21:0]. When use_imm_i is 0, the first operand is src_a_i.
- R7: Operation code 9 shifts src_a_i left. The count is src_b_i when use_imm_i is 0 and cnt_i when use_imm_i is 1. A register count above 63 gives zero.
- R8: Code 10 is the arithmetic right shift of src_a_i and code 11 is the logical right shift, with the count chosen as in R7. For a register count above 63, code 10 fills the result with bit 63 of src_a_i and code 11 gives zero.
- R9: wen_o equals valid_i AND qp_i, delayed by one clock.
- R10: When valid_i AND qp_i is 0, res_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation slot is occupied |
| qp_i | input | 1 | Qualifying predicate |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Immediate first operand, or immediate shift count |
| imm_sz_i | input | 2 | Immediate width select |
| imm_i | input | 22 | Raw immediate field |
| cnt_i | input | 6 | Immediate shift count; bits [1:0] also give the shifted-add amount |
| src_a_i | input | 64 | First register operand |
| src_b_i | input | 64 | Second register operand |
| res_o | output | 64 | Registered result |
| wen_o | output | 1 | Registered write enable |

## Verification
Every operation code is driven with random 64-bit operands in both the register form and the immediate form, across all three immediate widths. This separates the operand-select and sign-extension paths from the datapath itself. The shift operations are also driven with the counts 0, 63 and 64 and with very large register counts. These values show apart the in-range barrel path, the zero result, and the sign-fill behaviour of the arithmetic right shift for both signs of src_a_i. The predicate and valid bits are randomised on their own, so held results can be told apart from written ones.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;
  localparam int XLEN  = 64;
  localparam int IMM_W = 22;
  localparam int CNT_W = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADD1   = 4'd1,
    OP_SUB    = 4'd2,
    OP_SUB1   = 4'd3,
    OP_SHLADD = 4'd4,
    OP_AND    = 4'd5,
    OP_OR     = 4'd6,
    OP_XOR    = 4'd7,
    OP_ANDCM  = 4'd8,
    OP_SHL    = 4'd9,
    OP_SHRS   = 4'd10,
    OP_SHRU   = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } sh_kind_e;

  typedef enum logic [1:0] {
    LG_AND   = 2'd0,
    LG_OR    = 2'd1,
    LG_XOR   = 2'd2,
    LG_ANDCM = 2'd3
  } lg_kind_e;
endpackage

// File: rtl/pred_alu_immext.sv
module pred_alu_immext #(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 22,
  parameter int NARROW = 8,
  parameter int MID    = 14
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       sz_i,
  output logic [XLEN-1:0]  ext_o
);
  always_comb begin
    case (sz_i)
      2'd0:    ext_o = {{(XLEN-NARROW){imm_i[NARROW-1]}}, imm_i[NARROW-1:0]};
      2'd1:    ext_o = {{(XLEN-MID){imm_i[MID-1]}}, imm_i[MID-1:0]};
      default: ext_o = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    endcase
  end
endmodule

// File: rtl/pred_alu_adder.sv
module pred_alu_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] x_i,
  input  logic [XLEN-1:0] y_i,
  input  logic [1:0]      pre_sh_i,  // shifted-add amount minus one
  input  logic            pre_en_i,
  input  logic            inv_y_i,
  input  logic            cin_i,
  output logic [XLEN-1:0] sum_o
);
  logic [XLEN-1:0] x_sh, y_m;
  logic [2:0]      amt;

  assign amt   = {1'b0, pre_sh_i} + 3'd1;
  assign x_sh  = pre_en_i ? (x_i << amt) : x_i;
  assign y_m   = inv_y_i ? ~y_i : y_i;
  assign sum_o = x_sh + y_m + {{(XLEN-1){1'b0}}, cin_i};
endmodule

// File: rtl/pred_alu_logic.sv
module pred_alu_logic
  import pred_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] x_i,
  input  logic [XLEN-1:0] y_i,
  input  lg_kind_e        kind_i,
  output logic [XLEN-1:0] res_o
);
  always_comb begin
    case (kind_i)
      LG_AND:  res_o = x_i & y_i;
      LG_OR:   res_o = x_i | y_i;
      LG_XOR:  res_o = x_i ^ y_i;
      default: res_o = x_i & ~y_i;
    endcase
  end
endmodule

// File: rtl/pred_alu_shift.sv
module pred_alu_shift
  import pred_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [XLEN-1:0] cnt_i,
  input  sh_kind_e        kind_i,
  output logic [XLEN-1:0] res_o
);
  localparam int CW = $clog2(XLEN);

  logic          over;
  logic [CW-1:0] amt;
  logic [XLEN-1:0] sl, srl, sra;

  assign over = |cnt_i[XLEN-1:CW];
  assign amt  = cnt_i[CW-1:0];
  assign sl   = val_i << amt;
  assign srl  = val_i >> amt;
  assign sra  = $signed(val_i) >>> amt;

  always_comb begin
    case (kind_i)
      SH_LEFT: res_o = over ? '0 : sl;
      SH_RLOG: res_o = over ? '0 : srl;
      default: res_o = over ? {XLEN{val_i[XLEN-1]}} : sra;
    endcase
  end
endmodule

// File: rtl/pred_int_alu.sv
module pred_int_alu
  import pred_alu_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int IW     = IMM_W,
  parameter int CW     = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          qp_i,
  input  logic [3:0]    op_i,
  input  logic          use_imm_i,
  input  logic [1:0]    imm_sz_i,
  input  logic [IW-1:0] imm_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [W-1:0]  src_a_i,
  input  logic [W-1:0]  src_b_i,
  output logic [W-1:0]  res_o,
  output logic          wen_o
);
  op_e op;
  assign op = op_e'(op_i);

  logic [W-1:0] imm_ext, first, sh_cnt;
  logic [W-1:0] sum, lg_res, sh_res;
  logic         is_arith, is_logic, is_shift, pre_en, inv_y, cin;
  lg_kind_e     lg_kind;
  sh_kind_e     sh_kind;
  logic [W-1:0] nxt;
  logic         do_wr;

  pred_alu_immext #(.XLEN(W), .IMM_W(IW)) u_imm (
    .imm_i (imm_i),
    .sz_i  (imm_sz_i),
    .ext_o (imm_ext)
  );

  assign first  = use_imm_i ? imm_ext : src_a_i;
  assign sh_cnt = use_imm_i ? {{(W-CW){1'b0}}, cnt_i} : src_b_i;

  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    is_shift = 1'b0;
    pre_en   = 1'b0;
    inv_y    = 1'b0;
    cin      = 1'b0;
    lg_kind  = LG_AND;
    sh_kind  = SH_LEFT;
    case (op)
      OP_ADD:    is_arith = 1'b1;
      OP_ADD1:   begin is_arith = 1'b1; cin = 1'b1; end
      OP_SUB:    begin is_arith = 1'b1; inv_y = 1'b1; cin = 1'b1; end
      OP_SUB1:   begin is_arith = 1'b1; inv_y = 1'b1; end
      OP_SHLADD: begin is_arith = 1'b1; pre_en = 1'b1; end
      OP_AND:    is_logic = 1'b1;
      OP_OR:     begin is_logic = 1'b1; lg_kind = LG_OR; end
      OP_XOR:    begin is_logic = 1'b1; lg_kind = LG_XOR; end
      OP_ANDCM:  begin is_logic = 1'b1; lg_kind = LG_ANDCM; end
      OP_SHL:    is_shift = 1'b1;
      OP_SHRS:   begin is_shift = 1'b1; sh_kind = SH_RARI; end
      OP_SHRU:   begin is_shift = 1'b1; sh_kind = SH_RLOG; end
      default:   ;
    endcase
  end

  // shifted add always takes the register operand as the shifted value
  pred_alu_adder #(.XLEN(W)) u_add (
    .x_i      (pre_en ? src_a_i : first),
    .y_i      (src_b_i),
    .pre_sh_i (cnt_i[1:0]),
    .pre_en_i (pre_en),
    .inv_y_i  (inv_y),
    .cin_i    (cin),
    .sum_o    (sum)
  );

  pred_alu_logic #(.XLEN(W)) u_lg (
    .x_i    (first),
    .y_i    (src_b_i),
    .kind_i (lg_kind),
    .res_o  (lg_res)
  );

  pred_alu_shift #(.XLEN(W)) u_sh (
    .val_i  (src_a_i),
    .cnt_i  (sh_cnt),
    .kind_i (sh_kind),
    .res_o  (sh_res)
  );

  always_comb begin
    nxt = '0;
    if (is_arith)      nxt = sum;
    else if (is_logic) nxt = lg_res;
    else if (is_shift) nxt = sh_res;
  end

  assign do_wr = valid_i & qp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      wen_o <= 1'b0;
    end else begin
      wen_o <= do_wr;
      if (do_wr) res_o <= nxt;
    end
  end
endmodule

// File: rtl/pred_int_alu_chk.sv
module pred_int_alu_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         qp_i,
  input logic [3:0]   op_i,
  input logic         use_imm_i,
  input logic [W-1:0] src_a_i,
  input logic [W-1:0] src_b_i,
  input logic [W-1:0] res_o,
  input logic         wen_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_zero: assert (res_o == '0 && !wen_o);
  end

  a_r9_wen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (wen_o == $past(valid_i && qp_i)));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !$past(valid_i && qp_i)) |-> $stable(res_o));

  a_r2_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(valid_i && qp_i && op_i == 4'd0 && !use_imm_i))
    |-> (res_o == $past(src_a_i + src_b_i)));

  a_r7_shl_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(valid_i && qp_i && op_i == 4'd9 && !use_imm_i && src_b_i > 63))
    |-> (res_o == '0));

  a_r8_sra_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(valid_i && qp_i && op_i == 4'd10 && !use_imm_i && src_b_i > 63))
    |-> (res_o == {W{$past(src_a_i[W-1])}}));
endmodule

bind pred_int_alu pred_int_alu_chk #(.W(W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .qp_i      (qp_i),
  .op_i      (op_i),
  .use_imm_i (use_imm_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .res_o     (res_o),
  .wen_o     (wen_o)
);

// File: tb/pred_int_alu_tb_top.sv
module pred_int_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, qp_i = 1'b0, use_imm_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  imm_sz_i = '0;
  logic [21:0] imm_i = '0;
  logic [5:0]  cnt_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic [63:0] res_o;
  logic        wen_o;

  int checks = 0, errors = 0;
  logic [63:0] exp_res = '0;
  logic        exp_wen = 1'b0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pred_int_alu dut_i (.*);

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4:       return "R4";
      4'd5, 4'd6, 4'd7, 4'd8: return "R5";
      4'd9:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  function automatic logic [63:0] sext(input logic [21:0] v, input logic [1:0] sz);
    longint s;
    if (sz == 2'd0)      s = longint'($signed(v[7:0]));
    else if (sz == 2'd1) s = longint'($signed(v[13:0]));
    else                 s = longint'($signed(v));
    return 64'(s);
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic ui,
      input logic [1:0] sz, input logic [21:0] imm, input logic [5:0] c,
      input logic [63:0] a, input logic [63:0] b);
    logic [63:0] f;
    logic [63:0] n;
    f = ui ? sext(imm, sz) : a;
    n = ui ? {58'd0, c} : b;
    case (op)
      4'd0:  return f + b;
      4'd1:  return f + b + 64'd1;
      4'd2:  return f - b;
      4'd3:  return f - b - 64'd1;
      4'd4:  return a * (64'd1 << (int'(c[1:0]) + 1)) + b;
      4'd5:  return f & b;
      4'd6:  return f | b;
      4'd7:  return f ^ b;
      4'd8:  return f & ~b;
      4'd9:  return (n > 63) ? 64'd0 : a << n;
      4'd10: begin
        if (n > 63) return a[63] ? '1 : '0;
        return 64'($signed(a) >>> n);
      end
      4'd11: return (n > 63) ? 64'd0 : a >> n;
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input string req);
    checks++;
    if (res_o !== exp_res || wen_o !== exp_wen) begin
      errors++;
      $display("FAIL %s: res=%h wen=%b expected res=%h wen=%b", req, res_o, wen_o, exp_res, exp_wen);
    end
  endtask

  // present one operation, check the registered result one clock later
  task automatic issue(input logic v, input logic q, input logic [3:0] op, input logic ui,
      input logic [1:0] sz, input logic [21:0] imm, input logic [5:0] c,
      input logic [63:0] a, input logic [63:0] b);
    string req;
    valid_i = v; qp_i = q; op_i = op; use_imm_i = ui; imm_sz_i = sz;
    imm_i = imm; cnt_i = c; src_a_i = a; src_b_i = b;
    exp_wen = v & q;
    if (v & q) exp_res = model(op, ui, sz, imm, c, a, b);
    req = (v & q) ? req_of(op) : "R10";
    @(negedge clk_i);
    chk(req);
    if (!(v & q)) chk("R9");
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    @(negedge clk_i);
    checks++;
    if (res_o !== 64'd0 || wen_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: res=%h wen=%b expected res=0 wen=0", res_o, wen_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2/R3 directed
    issue(1, 1, 4'd0, 0, 0, 0, 0, 64'd5, 64'd7);
    issue(1, 1, 4'd1, 0, 0, 0, 0, '1, 64'd0);
    issue(1, 1, 4'd2, 0, 0, 0, 0, 64'd3, 64'd5);
    issue(1, 1, 4'd3, 0, 0, 0, 0, 64'd0, 64'd0);
    // R4 all four shift amounts
    for (int k = 0; k < 4; k++) issue(1, 1, 4'd4, 0, 0, 0, 6'(k), 64'h8000_0000_0000_0003, 64'd1);
    // R5 and-complement
    issue(1, 1, 4'd8, 0, 0, 0, 0, 64'hFF00, 64'h0F00);
    // R6 immediate widths, negative values
    issue(1, 1, 4'd0, 1, 2'd0, 22'h3FFF80, 0, 0, 64'd0);
    issue(1, 1, 4'd0, 1, 2'd1, 22'h002000, 0, 0, 64'd0);
    issue(1, 1, 4'd0, 1, 2'd2, 22'h200000, 0, 0, 64'd0);
    issue(1, 1, 4'd8, 1, 2'd0, 22'h0000FF, 0, 0, 64'h1);
    // R7/R8 edge counts, both signs
    for (int s = 0; s < 2; s++) begin
      logic [63:0] a;
      a = s ? 64'h8123_4567_89AB_CDEF : 64'h0123_4567_89AB_CDEF;
      for (int op = 9; op < 12; op++) begin
        issue(1, 1, 4'(op), 0, 0, 0, 0, a, 64'd0);
        issue(1, 1, 4'(op), 0, 0, 0, 0, a, 64'd63);
        issue(1, 1, 4'(op), 0, 0, 0, 0, a, 64'd64);
        issue(1, 1, 4'(op), 0, 0, 0, 0, a, 64'h8000_0000_0000_0000);
        issue(1, 1, 4'(op), 1, 0, 0, 6'd63, a, 64'd64);
        issue(1, 1, 4'(op), 1, 0, 0, 6'd0, a, 64'd99);
      end
    end
    // R9/R10 suppressed writes
    issue(1, 0, 4'd0, 0, 0, 0, 0, 64'd1, 64'd1);
    issue(0, 1, 4'd6, 0, 0, 0, 0, '1, '1);

    for (int i = 0; i < N_RAND; i++) begin
      logic [3:0]  op;
      logic [63:0] b;
      logic [5:0]  c;
      op = 4'($urandom_range(0, 11));
      case ($urandom_range(0, 4))
        0: b = 64'd0;
        1: b = 64'd63;
        2: b = 64'd64;
        3: b = 64'($urandom_range(0, 80));
        default: b = r64();
      endcase
      case ($urandom_range(0, 2))
        0: c = 6'd0;
        1: c = 6'd63;
        default: c = 6'($urandom);
      endcase
      issue(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 5) != 0), op,
            1'($urandom), 2'($urandom), 22'($urandom), c, r64(), b);
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule